// File: doc/BRIEF.md
# Preferred-Order Multithread Issue Slot Allocator

This block decides, once per cycle, which instructions from several hardware threads go to a shared set of functional units. By default there are three threads and four units: two integer ALUs, one memory port that serves a load or a store, and one branch unit. Each thread shows the allocator a short window of its oldest pending instructions. Each entry has a two-bit unit class and a stall bit.

Threads are served in a fixed order of preference: thread 0 first, then thread 1, then thread 2. Each thread walks its window from the oldest entry. It claims a unit for each entry until it meets an entry that cannot be placed. An entry cannot be placed when it is stalled, when it is an empty entry, or when its unit class has no slot left. Entries of one thread with no stall between them count as independent, so they may issue together in the same cycle.

The result is registered. It gives a busy flag for each unit slot, the thread that owns each slot, and a per-thread advance count. The front end uses the advance count to pop exactly the instructions that issued.

Top module: `smt_issue_alloc`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: At most NUM_ALU ALU-class entries, NUM_MEM memory-class entries and NUM_BR branch-class entries are granted per cycle. Slots 0..NUM_ALU-1 are the ALUs. Slot NUM_ALU is the memory port. Slot NUM_ALU+NUM_MEM is the branch unit.
- R3: A thread issues only a contiguous prefix of its window, starting at entry 0. It stops at the first entry whose unit class has no slot left, even if a later entry could have been placed.
- R4: A stalled entry (stall bit 1) ends that thread's issue for the cycle. A thread whose entry 0 is stalled advances by 0, and its units stay free for the threads after it.
- R5: Threads are served in index order, 0 before 1 before 2. A thread only receives units that every lower-index thread left unused.
- R6: Class codes are: 0 = ALU, 1 = memory (load or store), 2 = branch, 3 = empty. An empty entry ends that thread's issue for the cycle.
- R7: `slot_thread` gives the index of the thread that owns each busy slot. Within a unit class, the lowest-numbered slots go to the thread served first. An idle slot reports thread 0.
- R8: The advance count of each thread equals the number of slots it holds. The sum of all advance counts equals the number of busy slots.
- R9: The outputs reflect the window inputs present at the previous rising clock edge. They change only at a clock edge.
- R10: A cycle in which no entry can issue reports every slot idle and every advance count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_class | input | NUM_THREADS*WINDOW*2 | Class code of entry j of thread t, at bits [(t*WINDOW+j)*2 +: 2] |
| win_stall | input | NUM_THREADS*WINDOW | Stall bit of entry j of thread t, at bit t*WINDOW+j |
| slot_busy | output | NUM_ALU+NUM_MEM+NUM_BR | Slot k is granted this cycle |
| slot_thread | output | (NUM_ALU+NUM_MEM+NUM_BR)*TW | Owning thread of slot k, at bits [k*TW +: TW] |
| thread_adv | output | NUM_THREADS*AW | Instructions issued by thread t, at bits [t*AW +: AW] |

## Verification
The bench targets three kinds of bug. The first is a thread that skips over a blocked entry and issues a later one. That design would report a larger advance count than the prefix rule allows. The second is a stall or empty entry that does not end the thread's issue, or a head stall that still holds units. In that case a lower-priority thread would lose slots it should have received. The third is wrong slot ordering or wrong priority, which shows up as swapped thread IDs on the two ALU slots or a later thread taking the single memory or branch slot. Random windows with frequent stalls and empty codes are mixed with directed windows for each of these cases. A separate check samples just before each edge to confirm the one-cycle registered timing.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;
   localparam int CLASS_W = 2;

   typedef enum logic [CLASS_W-1:0] {
      UC_ALU  = 2'd0,
      UC_MEM  = 2'd1,
      UC_BR   = 2'd2,
      UC_NONE = 2'd3
   } unit_class_e;
endpackage

// File: rtl/smt_thread_scan.sv
// Walks one thread's window in order and claims free units until blocked.
module smt_thread_scan
   import smt_issue_pkg::*;
#(
   parameter int WINDOW = 4,
   parameter int CW     = 3,
   parameter int AW     = 3
) (
   input  logic [WINDOW*CLASS_W-1:0] cls_i,
   input  logic [WINDOW-1:0]         stall_i,
   input  logic [CW-1:0]             free_alu_i,
   input  logic [CW-1:0]             free_mem_i,
   input  logic [CW-1:0]             free_br_i,
   output logic [CW-1:0]             take_alu_o,
   output logic [CW-1:0]             take_mem_o,
   output logic [CW-1:0]             take_br_o,
   output logic [AW-1:0]             adv_o
);
   always_comb begin
      logic        going;
      unit_class_e cls;
      going      = 1'b1;
      take_alu_o = '0;
      take_mem_o = '0;
      take_br_o  = '0;
      adv_o      = '0;
      for (int j = 0; j < WINDOW; j++) begin
         cls = unit_class_e'(cls_i[j*CLASS_W +: CLASS_W]);
         if (going) begin
            if (stall_i[j]) begin
               going = 1'b0;
            end else begin
               unique case (cls)
                  UC_ALU: if (take_alu_o < free_alu_i) begin
                     take_alu_o = take_alu_o + CW'(1);
                     adv_o      = adv_o + AW'(1);
                  end else going = 1'b0;
                  UC_MEM: if (take_mem_o < free_mem_i) begin
                     take_mem_o = take_mem_o + CW'(1);
                     adv_o      = adv_o + AW'(1);
                  end else going = 1'b0;
                  UC_BR: if (take_br_o < free_br_i) begin
                     take_br_o = take_br_o + CW'(1);
                     adv_o     = adv_o + AW'(1);
                  end else going = 1'b0;
                  default: going = 1'b0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/smt_slot_map.sv
// Lays per-thread grant counts of one unit class onto that class's slots.
module smt_slot_map #(
   parameter int NT = 3,
   parameter int NS = 2,
   parameter int CW = 3,
   parameter int TW = 2
) (
   input  logic [NT*CW-1:0] take_i,
   output logic [NS-1:0]    busy_o,
   output logic [NS*TW-1:0] tid_o
);
   always_comb begin
      int lo;
      int hi;
      busy_o = '0;
      tid_o  = '0;
      hi     = 0;
      for (int t = 0; t < NT; t++) begin
         lo = hi;
         hi = hi + int'(take_i[t*CW +: CW]);
         for (int k = 0; k < NS; k++) begin
            if (k >= lo && k < hi) begin
               busy_o[k]          = 1'b1;
               tid_o[k*TW +: TW]  = TW'(t);
            end
         end
      end
   end
endmodule

// File: rtl/smt_issue_alloc.sv
module smt_issue_alloc
   import smt_issue_pkg::*;
#(
   parameter int NUM_THREADS = 3,
   parameter int WINDOW      = 4,
   parameter int NUM_ALU     = 2,
   parameter int NUM_MEM     = 1,
   parameter int NUM_BR      = 1,
   localparam int NSLOT = NUM_ALU + NUM_MEM + NUM_BR,
   localparam int TW    = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int AW    = $clog2(WINDOW + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_THREADS*WINDOW*2-1:0] win_class,
   input  logic [NUM_THREADS*WINDOW-1:0]   win_stall,
   output logic [NSLOT-1:0]                slot_busy,
   output logic [NSLOT*TW-1:0]             slot_thread,
   output logic [NUM_THREADS*AW-1:0]       thread_adv
);
   localparam int M1 = (WINDOW > NUM_ALU) ? WINDOW : NUM_ALU;
   localparam int M2 = (M1 > NUM_MEM) ? M1 : NUM_MEM;
   localparam int M3 = (M2 > NUM_BR) ? M2 : NUM_BR;
   localparam int CW = $clog2(M3 + 1);

   generate
      if (NUM_THREADS < 1 || WINDOW < 1) begin : g_bad_shape
         $error("smt_issue_alloc: NUM_THREADS and WINDOW must be at least 1");
      end
      if (NUM_ALU < 1 || NUM_MEM < 1 || NUM_BR < 1) begin : g_bad_units
         $error("smt_issue_alloc: each unit class needs at least one slot");
      end
   endgenerate

   logic [CW-1:0] free_alu [NUM_THREADS+1];
   logic [CW-1:0] free_mem [NUM_THREADS+1];
   logic [CW-1:0] free_br  [NUM_THREADS+1];
   logic [NUM_THREADS*CW-1:0] take_alu, take_mem, take_br;
   logic [NUM_THREADS*AW-1:0] adv_d;

   assign free_alu[0] = CW'(NUM_ALU);
   assign free_mem[0] = CW'(NUM_MEM);
   assign free_br[0]  = CW'(NUM_BR);

   // Priority chain: each thread sees only what earlier threads left.
   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         smt_thread_scan #(.WINDOW(WINDOW), .CW(CW), .AW(AW)) u_scan (
            .cls_i      (win_class[t*WINDOW*CLASS_W +: WINDOW*CLASS_W]),
            .stall_i    (win_stall[t*WINDOW +: WINDOW]),
            .free_alu_i (free_alu[t]),
            .free_mem_i (free_mem[t]),
            .free_br_i  (free_br[t]),
            .take_alu_o (take_alu[t*CW +: CW]),
            .take_mem_o (take_mem[t*CW +: CW]),
            .take_br_o  (take_br[t*CW +: CW]),
            .adv_o      (adv_d[t*AW +: AW])
         );
         assign free_alu[t+1] = free_alu[t] - take_alu[t*CW +: CW];
         assign free_mem[t+1] = free_mem[t] - take_mem[t*CW +: CW];
         assign free_br[t+1]  = free_br[t]  - take_br[t*CW +: CW];
      end
   endgenerate

   logic [NUM_ALU-1:0]    alu_busy;
   logic [NUM_MEM-1:0]    mem_busy;
   logic [NUM_BR-1:0]     br_busy;
   logic [NUM_ALU*TW-1:0] alu_tid;
   logic [NUM_MEM*TW-1:0] mem_tid;
   logic [NUM_BR*TW-1:0]  br_tid;

   smt_slot_map #(.NT(NUM_THREADS), .NS(NUM_ALU), .CW(CW), .TW(TW)) u_map_alu (
      .take_i (take_alu), .busy_o (alu_busy), .tid_o (alu_tid));
   smt_slot_map #(.NT(NUM_THREADS), .NS(NUM_MEM), .CW(CW), .TW(TW)) u_map_mem (
      .take_i (take_mem), .busy_o (mem_busy), .tid_o (mem_tid));
   smt_slot_map #(.NT(NUM_THREADS), .NS(NUM_BR), .CW(CW), .TW(TW)) u_map_br (
      .take_i (take_br), .busy_o (br_busy), .tid_o (br_tid));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_busy   <= '0;
         slot_thread <= '0;
         thread_adv  <= '0;
      end else begin
         slot_busy   <= {br_busy, mem_busy, alu_busy};
         slot_thread <= {br_tid, mem_tid, alu_tid};
         thread_adv  <= adv_d;
      end
   end
endmodule

// File: rtl/smt_issue_alloc_chk.sv
module smt_issue_alloc_chk #(
   parameter int NT      = 3,
   parameter int W       = 4,
   parameter int NS      = 4,
   parameter int NUM_ALU = 2,
   parameter int TW      = 2,
   parameter int AW      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NT*W-1:0]  win_stall,
   input logic [NS-1:0]    slot_busy,
   input logic [NS*TW-1:0] slot_thread,
   input logic [NT*AW-1:0] thread_adv
);
   int adv_sum;
   always_comb begin
      adv_sum = 0;
      for (int t = 0; t < NT; t++) adv_sum = adv_sum + int'(thread_adv[t*AW +: AW]);
   end

   // R8
   adv_matches_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_sum == $countones(slot_busy));

   generate
      for (genvar k = 0; k < NS; k++) begin : g_slot
         // R7
         idle_slot_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_busy[k] |-> slot_thread[k*TW +: TW] == '0);
      end
      for (genvar k = 1; k < NUM_ALU; k++) begin : g_alu
         // R2
         alu_fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_busy[k] |-> slot_busy[k-1]);
         // R5
         alu_prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_busy[k] && slot_busy[k-1]) |->
               slot_thread[k*TW +: TW] >= slot_thread[(k-1)*TW +: TW]);
      end
      for (genvar t = 0; t < NT; t++) begin : g_thr
         // R4
         head_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(win_stall[t*W])) |-> thread_adv[t*AW +: AW] == '0);
      end
   endgenerate
endmodule

bind smt_issue_alloc smt_issue_alloc_chk #(
   .NT(NUM_THREADS), .W(WINDOW), .NS(NSLOT), .NUM_ALU(NUM_ALU), .TW(TW), .AW(AW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .win_stall   (win_stall),
   .slot_busy   (slot_busy),
   .slot_thread (slot_thread),
   .thread_adv  (thread_adv)
);

// File: tb/smt_issue_alloc_tb.sv
module smt_issue_alloc_tb;
   localparam int NT = 3;
   localparam int W  = 4;
   localparam int NS = 4;
   localparam int TW = 2;
   localparam int AW = 3;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NT*W*2-1:0]   win_class = '0;
   logic [NT*W-1:0]     win_stall = '0;
   logic [NS-1:0]       slot_busy;
   logic [NS*TW-1:0]    slot_thread;
   logic [NT*AW-1:0]    thread_adv;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [NS-1:0]    p_busy = '0;
   logic [NS*TW-1:0] p_tid  = '0;
   logic [NT*AW-1:0] p_adv  = '0;

   always #5 clk = ~clk;

   smt_issue_alloc u_dut (
      .clk(clk), .rst_n(rst_n), .win_class(win_class), .win_stall(win_stall),
      .slot_busy(slot_busy), .slot_thread(slot_thread), .thread_adv(thread_adv));

   // Behavioural reference: slots 0,1 ALU, 2 MEM, 3 BR; threads served in index order.
   task automatic model(input logic [NT*W*2-1:0] c, input logic [NT*W-1:0] s,
                        output logic [NS-1:0] busy, output logic [NS*TW-1:0] tid,
                        output logic [NT*AW-1:0] adv);
      int fa = 2; int fm = 1; int fb = 1;
      busy = '0; tid = '0; adv = '0;
      for (int t = 0; t < NT; t++) begin
         bit go = 1'b1;
         int n = 0;
         for (int j = 0; j < W; j++) begin
            logic [1:0] k;
            k = c[(t*W+j)*2 +: 2];
            if (go) begin
               if (s[t*W+j]) go = 1'b0;
               else if (k == 2'd0 && fa > 0) begin
                  busy[2-fa] = 1'b1; tid[(2-fa)*TW +: TW] = TW'(t); fa--; n++;
               end else if (k == 2'd1 && fm > 0) begin
                  busy[2] = 1'b1; tid[2*TW +: TW] = TW'(t); fm--; n++;
               end else if (k == 2'd2 && fb > 0) begin
                  busy[3] = 1'b1; tid[3*TW +: TW] = TW'(t); fb--; n++;
               end else go = 1'b0;
            end
         end
         adv[t*AW +: AW] = AW'(n);
      end
   endtask

   task automatic compare(input string req, input logic [NS-1:0] eb,
                          input logic [NS*TW-1:0] et, input logic [NT*AW-1:0] ea);
      n_vec++;
      if (slot_busy !== eb || slot_thread !== et || thread_adv !== ea) begin
         n_bad++;
         $display("FAIL %s: busy=%b tid=%h adv=%h expected busy=%b tid=%h adv=%h",
                  req, slot_busy, slot_thread, thread_adv, eb, et, ea);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic apply(input logic [NT*W*2-1:0] c, input logic [NT*W-1:0] s, input string req);
      logic [NS-1:0] eb; logic [NS*TW-1:0] et; logic [NT*AW-1:0] ea;
      model(c, s, eb, et, ea);
      win_class = c;
      win_stall = s;
      #2;
      compare("R9 (no change before edge)", p_busy, p_tid, p_adv);
      @(negedge clk);
      compare(req, eb, et, ea);
      p_busy = eb; p_tid = et; p_adv = ea;
   endtask

   // Entries listed oldest last: {e3,e2,e1,e0}
   function automatic logic [NT*W*2-1:0] win(input logic [7:0] t0, input logic [7:0] t1,
                                              input logic [7:0] t2);
      return {t2, t1, t0};
   endfunction

   localparam logic [7:0] EMPTY = 8'hFF;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R9: watchdog expired, actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      win_class = '0;
      win_stall = '0;
      repeat (3) @(negedge clk);
      compare("R1 reset state", '0, '0, '0);
      rst_n = 1'b1;

      // R10: every window empty
      apply({NT*W{2'd3}}, '0, "R10 all empty");
      // R3 R5: thread 0 blocks at third ALU; thread 1 takes BR then MEM; thread 2 starved
      apply(win({2'd2,2'd0,2'd0,2'd0}, {2'd0,2'd0,2'd1,2'd2}, {2'd1,2'd2,2'd1,2'd0}),
            '0, "R3 R5 prefix and priority");
      // R4: thread 0 head stalled frees both ALUs for thread 1
      apply(win({2'd0,2'd0,2'd0,2'd0}, {2'd2,2'd1,2'd0,2'd0}, {2'd0,2'd0,2'd0,2'd0}),
            12'h001, "R4 head stall");
      // R4: stall in the middle of thread 0 stops it after one ALU
      apply(win({2'd0,2'd2,2'd1,2'd0}, {2'd1,2'd3,2'd3,2'd3}, {2'd2,2'd0,2'd3,2'd0}),
            12'h002, "R4 mid-window stall");
      // R6: empty code ends thread 0; thread 1 gets the second ALU
      apply(win({2'd1,2'd0,2'd3,2'd0}, {2'd3,2'd2,2'd0,2'd0}, EMPTY),
            '0, "R6 empty entry ends window");
      // R7: only thread 2 active, fills all four slots
      apply(win(EMPTY, EMPTY, {2'd0,2'd1,2'd0,2'd2}), '0, "R7 low-priority owner");
      // R2: memory contention, second MEM of thread 0 blocks, thread 1 MEM blocked too
      apply(win({2'd0,2'd1,2'd1,2'd0}, {2'd0,2'd0,2'd1,2'd1}, {2'd2,2'd2,2'd2,2'd0}),
            '0, "R2 unit limits");
      // R8: each thread one ALU/MEM/BR split
      apply(win({2'd3,2'd3,2'd3,2'd0}, {2'd3,2'd3,2'd0,2'd1}, {2'd3,2'd3,2'd2,2'd0}),
            '0, "R8 advance counts");

      for (int i = 0; i < 400; i++) begin
         logic [NT*W*2-1:0] c;
         logic [NT*W-1:0]   s;
         c = {$urandom, $urandom};
         for (int b = 0; b < NT*W; b++) s[b] = ($urandom % 4) == 0;
         apply(c, s, "R2 R3 R4 R5 R6 R7 R8 random");
      end

      // R1: reset mid-run clears outputs
      win_class = {NT*W{2'd0}};
      rst_n = 1'b0;
      #2;
      compare("R1 async reset", '0, '0, '0);
      @(negedge clk);
      compare("R1 held in reset", '0, '0, '0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule